// File: doc/BRIEF.md
# Matrix Converter Two-Stage Space Vector Sequencer

This block drives the nine bidirectional switches of a three-input, three-output matrix converter. Each switching period it takes the sector and two duty words of a virtual rectifier stage, and the sector and two duty words of a virtual inverter stage. It merges them into one sequence of four active states and one zero state. Each active state's duration is the product of one rectifier duty and one inverter duty. The zero state takes whatever time is left in the period.

The sequence is laid out symmetrically about the zero state. Every combined state is expressed as one input-phase selector per output phase, and a decoder turns each selector into switch enables. That structure means no input pair is ever shorted and no output is ever left open. The upstream controller supplies the period length, the sectors and the duty words. The block does the timing, the state choice and the guarding of the switch pattern.

Duty words are unsigned fractions of full scale: a word w stands for w / 2^DW. Sectors run from 0 to 5. Input phases are a, b, c (codes 0, 1, 2) and output phases are A, B, C (indices 0, 1, 2).

Top module: `mcsv_seq`

## Requirements
- R1: Bit 3*o+i of sw_o connects output o to input i. In every cycle exactly one of the three bits of each output is set.
- R2: While rst_ni is low, sw_o is 0x049 (every output on input a), period_strobe_o is 0 and fault_o is 0.
- R3: period_strobe_o is high for one cycle, in the cycle that shows the first state of a period. Strobes are P cycles apart, where P is the period word that was captured for that period.
- R4: Each half-segment length is floor(P*dx*dy / 2^(2*DW+1)), for each of the pairs alpha-gamma, alpha-delta, beta-delta and beta-gamma.
  - The period runs the states in this order: alpha-gamma, alpha-delta, beta-delta, beta-gamma, zero, beta-gamma, beta-delta, alpha-delta, alpha-gamma.
  - Each active state lasts its half length at each of its two appearances.
  - The zero state lasts P minus twice the sum of the half lengths.
  - A segment of length 0 is not emitted.
- R5: Rectifier vector k connects the positive rail to input p(k) and the negative rail to input n(k). The pairs (p, n) for k = 0..5 are (a,b), (a,c), (b,c), (b,a), (c,a), (c,b).
  - Gamma uses vector s, where s is the rectifier sector.
  - Delta uses vector (s+1) mod 6.
- R6: In inverter vector j, the outputs on the positive rail are A for j=0; A,B for j=1; B for j=2; B,C for j=3; C for j=4; and A,C for j=5. All other outputs are on the negative rail.
  - Alpha uses vector s, where s is the inverter sector.
  - Beta uses vector (s+1) mod 6.
- R7: In the zero state, all three outputs connect to one input phase. That phase is the one used by two of the three outputs in the adjacent beta-gamma state.
- R8: All inputs are captured once, in the last cycle of the preceding period. A change at any other time does not affect the running period.
- R9: When twice the sum of the half lengths exceeds P, the sequence is cut off at the period end and no zero state is emitted.
- R10: A sector value above 5 produces selector code 11 for every output. An output whose selector is 11 keeps its last legal switch pattern.
- R11: fault_o rises in the cycle after an illegal selector reaches the decoder, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| period_i | input | PW | Switching period in clock cycles |
| rect_sector_i | input | 3 | Input-current sector, 0..5 |
| inv_sector_i | input | 3 | Output-voltage sector, 0..5 |
| d_alpha_i | input | DW | First inverter duty |
| d_beta_i | input | DW | Second inverter duty |
| d_gamma_i | input | DW | First rectifier duty |
| d_delta_i | input | DW | Second rectifier duty |
| sw_o | output | 9 | Switch enables, bit 3*o+i = output o to input i |
| period_strobe_o | output | 1 | High with the first state of each period |
| fault_o | output | 1 | Sticky illegal-selector flag |

## Verification
Two situations are provoked on purpose.

The first is the end-of-period capture falling in the same period as an upstream update. The bench rewrites every input halfway through a period. It then expects the second half to follow the old configuration and the period that follows to follow the new one.

The second is an illegal sector arriving together with a period boundary. The strobe must keep its rhythm while every output freezes on the last state of the preceding legal period and the fault flag rises. After legal sectors return, the sequence is judged normal again while the flag stays set.

// File: rtl/mcsv_pkg.sv
package mcsv_pkg;
  typedef logic [1:0] phase_sel_t;

  localparam phase_sel_t SEL_BAD = 2'b11;
  localparam int N_OUT = 3;
  localparam int N_SEG = 9;
  localparam logic [3:0] SEG_ZERO = 4'd4;

  function automatic logic [2:0] next_sector(input logic [2:0] s);
    return (s >= 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

  // {positive-rail input, negative-rail input}
  function automatic logic [3:0] rect_pair(input logic [2:0] k);
    case (k)
      3'd0: return {2'd0, 2'd1};
      3'd1: return {2'd0, 2'd2};
      3'd2: return {2'd1, 2'd2};
      3'd3: return {2'd1, 2'd0};
      3'd4: return {2'd2, 2'd0};
      3'd5: return {2'd2, 2'd1};
      default: return {SEL_BAD, SEL_BAD};
    endcase
  endfunction

  // bit o set: output o on positive rail
  function automatic logic [2:0] inv_pattern(input logic [2:0] j);
    case (j)
      3'd0: return 3'b001;
      3'd1: return 3'b011;
      3'd2: return 3'b010;
      3'd3: return 3'b110;
      3'd4: return 3'b100;
      3'd5: return 3'b101;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/mcsv_duty.sv
module mcsv_duty #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic [PW-1:0]      period_i,
  input  logic [DW-1:0]      d_alpha_i,
  input  logic [DW-1:0]      d_beta_i,
  input  logic [DW-1:0]      d_gamma_i,
  input  logic [DW-1:0]      d_delta_i,
  output logic [3:0][PW-1:0] half_o
);
  localparam int PRW = PW + 2 * DW;
  localparam int SH  = 2 * DW + 1;

  // order: alpha-gamma, alpha-delta, beta-delta, beta-gamma
  for (genvar g = 0; g < 4; g++) begin : g_prod
    logic [DW-1:0] d_inv, d_rect;
    assign d_inv  = (g >= 2) ? d_beta_i : d_alpha_i;
    assign d_rect = (g == 1 || g == 2) ? d_delta_i : d_gamma_i;
    assign half_o[g] = PW'((PRW'(period_i) * PRW'(d_inv) * PRW'(d_rect)) >> SH);
  end
endmodule

// File: rtl/mcsv_timeline.sv
module mcsv_timeline import mcsv_pkg::*; #(
  parameter int PW = 12
) (
  input  logic [PW-1:0]      t_i,
  input  logic [PW-1:0]      plen_i,
  input  logic [3:0][PW-1:0] half_i,
  output logic [3:0]         seg_o
);
  localparam int CW = PW + 4;

  logic [CW-1:0] sum2, zlen;
  logic [N_SEG-2:0][CW-1:0] seg_len;

  always_comb begin
    sum2 = CW'(half_i[0]) + CW'(half_i[1]) + CW'(half_i[2]) + CW'(half_i[3]);
    sum2 = sum2 << 1;
    zlen = (CW'(plen_i) >= sum2) ? CW'(plen_i) - sum2 : '0;
  end

  // mirrored layout around the zero segment
  for (genvar s = 0; s < N_SEG - 1; s++) begin : g_len
    if (s == 4) begin : g_zero
      assign seg_len[s] = zlen;
    end else if (s < 4) begin : g_lead
      assign seg_len[s] = CW'(half_i[s]);
    end else begin : g_trail
      assign seg_len[s] = CW'(half_i[8 - s]);
    end
  end

  logic [CW-1:0] acc;
  logic [3:0]    seg;

  always_comb begin
    acc = '0;
    seg = '0;
    for (int s = 0; s < N_SEG - 1; s++) begin
      acc = acc + seg_len[s];
      if (CW'(t_i) >= acc) seg = seg + 4'd1;
    end
    seg_o = seg;
  end
endmodule

// File: rtl/mcsv_state_map.sv
module mcsv_state_map import mcsv_pkg::*; (
  input  logic [2:0]             rsec_i,
  input  logic [2:0]             isec_i,
  input  logic [3:0]             seg_i,
  output phase_sel_t [N_OUT-1:0] sel_o
);
  logic [2:0] k_sel, j_sel, pat;
  logic [3:0] pn, pn_g;
  phase_sel_t zph;
  logic       ok;

  always_comb begin
    k_sel = rsec_i;
    j_sel = isec_i;
    case (seg_i)
      4'd1, 4'd7: k_sel = next_sector(rsec_i);
      4'd2, 4'd6: begin
        k_sel = next_sector(rsec_i);
        j_sel = next_sector(isec_i);
      end
      4'd3, 4'd5: j_sel = next_sector(isec_i);
      default: ;
    endcase
    pn   = rect_pair(k_sel);
    pn_g = rect_pair(rsec_i);
    pat  = inv_pattern(j_sel);
    // even inverter sector: beta-gamma has two outputs on the positive rail
    zph  = isec_i[0] ? pn_g[1:0] : pn_g[3:2];
    ok   = (rsec_i < 3'd6) && (isec_i < 3'd6);
    for (int o = 0; o < N_OUT; o++) begin
      if (!ok)                   sel_o[o] = SEL_BAD;
      else if (seg_i == SEG_ZERO) sel_o[o] = zph;
      else                       sel_o[o] = pat[o] ? pn[3:2] : pn[1:0];
    end
  end
endmodule

// File: rtl/mcsv_sw_dec.sv
module mcsv_sw_dec import mcsv_pkg::*; (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  phase_sel_t [N_OUT-1:0] sel_i,
  output logic [3*N_OUT-1:0]     sw_o,
  output logic                   fault_o
);
  logic [N_OUT-1:0] bad;
  logic             fault_q;

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [2:0] grp_q;
    assign bad[o] = en_i && (sel_i[o] == SEL_BAD);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                grp_q <= 3'b001;
      else if (en_i && !bad[o])   grp_q <= 3'b001 << sel_i[o];
    end
    assign sw_o[3*o +: 3] = grp_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= fault_q | (|bad);
  end

  assign fault_o = fault_q;
endmodule

// File: rtl/mcsv_seq.sv
module mcsv_seq import mcsv_pkg::*; #(
  parameter int PW = 12,
  parameter int DW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PW-1:0]        period_i,
  input  logic [2:0]           rect_sector_i,
  input  logic [2:0]           inv_sector_i,
  input  logic [DW-1:0]        d_alpha_i,
  input  logic [DW-1:0]        d_beta_i,
  input  logic [DW-1:0]        d_gamma_i,
  input  logic [DW-1:0]        d_delta_i,
  output logic [3*N_OUT-1:0]   sw_o,
  output logic                 period_strobe_o,
  output logic                 fault_o
);
  logic                 valid_q, strobe_q, load;
  logic [PW-1:0]        t_q, plen_q;
  logic [PW:0]          t_nxt;
  logic [2:0]           rsec_q, isec_q;
  logic [3:0][PW-1:0]   half_w, half_q;
  logic [3:0]           seg_w;
  phase_sel_t [N_OUT-1:0] sel_w;

  mcsv_duty #(.PW(PW), .DW(DW)) u_duty (
    .period_i (period_i),
    .d_alpha_i(d_alpha_i),
    .d_beta_i (d_beta_i),
    .d_gamma_i(d_gamma_i),
    .d_delta_i(d_delta_i),
    .half_o   (half_w)
  );

  assign t_nxt = {1'b0, t_q} + 1'b1;
  assign load  = !valid_q || (t_nxt >= {1'b0, plen_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      strobe_q <= 1'b0;
      t_q      <= '0;
      plen_q   <= '0;
      rsec_q   <= '0;
      isec_q   <= '0;
      half_q   <= '0;
    end else begin
      valid_q  <= 1'b1;
      strobe_q <= valid_q && (t_q == '0);
      if (load) begin
        t_q    <= '0;
        plen_q <= period_i;
        rsec_q <= rect_sector_i;
        isec_q <= inv_sector_i;
        half_q <= half_w;
      end else begin
        t_q <= t_nxt[PW-1:0];
      end
    end
  end

  mcsv_timeline #(.PW(PW)) u_timeline (
    .t_i   (t_q),
    .plen_i(plen_q),
    .half_i(half_q),
    .seg_o (seg_w)
  );

  mcsv_state_map u_map (
    .rsec_i(rsec_q),
    .isec_i(isec_q),
    .seg_i (seg_w),
    .sel_o (sel_w)
  );

  mcsv_sw_dec u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (valid_q),
    .sel_i  (sel_w),
    .sw_o   (sw_o),
    .fault_o(fault_o)
  );

  assign period_strobe_o = strobe_q;
endmodule

// File: rtl/mcsv_seq_chk.sv
module mcsv_seq_chk import mcsv_pkg::*; (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [3*N_OUT-1:0]   sw_i,
  input logic                 fault_i,
  input logic                 en_i,
  input logic [2*N_OUT-1:0]   sel_i,
  input logic [3:0]           seg_i
);
  assert_onehot_groups_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(sw_i[2:0]) && $onehot(sw_i[5:3]) && $onehot(sw_i[8:6]));

  assert_seg_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_i <= 4'd8);

  assert_zero_uniform_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && seg_i == SEG_ZERO && sel_i[1:0] != SEL_BAD
    |=> sw_i[2:0] == sw_i[5:3] && sw_i[5:3] == sw_i[8:6]);

  assert_hold_a_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sel_i[1:0] == SEL_BAD |=> $stable(sw_i[2:0]));

  assert_hold_b_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sel_i[3:2] == SEL_BAD |=> $stable(sw_i[5:3]));

  assert_hold_c_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && sel_i[5:4] == SEL_BAD |=> $stable(sw_i[8:6]));

  assert_fault_raise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (sel_i[1:0] == SEL_BAD || sel_i[3:2] == SEL_BAD || sel_i[5:4] == SEL_BAD)
    |=> fault_i);

  assert_fault_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> fault_i);
endmodule

bind mcsv_seq mcsv_seq_chk i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .sw_i   (sw_o),
  .fault_i(fault_o),
  .en_i   (valid_q),
  .sel_i  (sel_w),
  .seg_i  (seg_w)
);

// File: tb/test_mcsv_seq.sv
module test_mcsv_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct {
    int p; int rs; int is; int da; int db; int dg; int dd;
  } cfg_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] period;
  logic [2:0]  rsec, isec;
  logic [7:0]  da, db, dg, dd;
  logic [8:0]  sw;
  logic        strobe, fault;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic exp_fault = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcsv_seq i_mcsv_seq (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .period_i       (period),
    .rect_sector_i  (rsec),
    .inv_sector_i   (isec),
    .d_alpha_i      (da),
    .d_beta_i       (db),
    .d_gamma_i      (dg),
    .d_delta_i      (dd),
    .sw_o           (sw),
    .period_strobe_o(strobe),
    .fault_o        (fault)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      checks++;
      $display("FAIL R3 watchdog: actual=no finish expected=finish within %0d cycles", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic int p_of(int k);
    return k / 2;
  endfunction

  function automatic int n_of(int k);
    case (k)
      0: return 1;
      1, 2: return 2;
      3, 4: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit hi(int o, int j);
    return (j == 2 * o) || (j == 2 * o + 1) || (j == (2 * o + 5) % 6);
  endfunction

  function automatic logic [8:0] exp_sw(cfg_t c, int k);
    int h[4];
    int len[9];
    int z, acc, seg, rk, ij, m;
    int ph[3];
    logic [8:0] r;
    h[0] = c.p * c.da * c.dg / 131072;
    h[1] = c.p * c.da * c.dd / 131072;
    h[2] = c.p * c.db * c.dd / 131072;
    h[3] = c.p * c.db * c.dg / 131072;
    z = c.p - 2 * (h[0] + h[1] + h[2] + h[3]);
    if (z < 0) z = 0;
    len = '{h[0], h[1], h[2], h[3], z, h[3], h[2], h[1], h[0]};
    seg = 0;
    acc = 0;
    for (int i = 0; i < 8; i++) begin
      acc += len[i];
      if (k >= acc) seg++;
    end
    rk = (seg == 1 || seg == 2 || seg == 6 || seg == 7) ? (c.rs + 1) % 6 : c.rs;
    ij = (seg == 2 || seg == 3 || seg == 5 || seg == 6) ? (c.is + 1) % 6 : c.is;
    if (seg == 4) begin
      rk = c.rs;
      ij = (c.is + 1) % 6;
    end
    for (int o = 0; o < 3; o++) ph[o] = hi(o, ij) ? p_of(rk) : n_of(rk);
    if (seg == 4) begin
      m = (ph[0] == ph[1] || ph[0] == ph[2]) ? ph[0] : ph[1];
      for (int o = 0; o < 3; o++) ph[o] = m;
    end
    r = '0;
    for (int o = 0; o < 3; o++) r[3 * o + ph[o]] = 1'b1;
    return r;
  endfunction

  task automatic drive(cfg_t c);
    period = 12'(c.p);
    rsec = 3'(c.rs);
    isec = 3'(c.is);
    da = 8'(c.da);
    db = 8'(c.db);
    dg = 8'(c.dg);
    dd = 8'(c.dd);
  endtask

  task automatic next_strobe();
    @(negedge clk);
    while (!strobe) @(negedge clk);
  endtask

  task automatic report(bit ok, string req, string what, int act, int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  // starts at the strobe sample of a period that runs configuration c
  task automatic check_period(cfg_t c, string tag, int mid_k, cfg_t nc);
    int bad_sw = 0, bad_oh = 0, bad_st = 0, bad_f = 0;
    int fk = -1;
    logic [8:0] fa = '0, fe = '0, e;
    for (int k = 0; k < c.p; k++) begin
      if (k > 0) @(negedge clk);
      e = exp_sw(c, k);
      if (sw !== e) begin
        bad_sw++;
        if (fk < 0) begin fk = k; fa = sw; fe = e; end
      end
      if (!($onehot(sw[2:0]) && $onehot(sw[5:3]) && $onehot(sw[8:6]))) bad_oh++;
      if (k > 0 && strobe !== 1'b0) bad_st++;
      if (fault !== exp_fault) bad_f++;
      if (k == mid_k) drive(nc);
    end
    @(negedge clk);
    if (strobe !== 1'b1) bad_st++;
    report(bad_sw == 0, tag, $sformatf("sequence k=%0d", fk), int'(fa), int'(fe));
    report(bad_oh == 0, "R1", "onehot violations", bad_oh, 0);
    report(bad_st == 0, "R3", "strobe placement errors", bad_st, 0);
    report(bad_f == 0, "R11", "fault flag mismatches", bad_f, 0);
  endtask

  task automatic run_period(cfg_t c, string tag);
    drive(c);
    next_strobe();
    next_strobe();
    check_period(c, tag, -1, c);
  endtask

  task automatic test_reset();
    report(sw === 9'h049, "R2", "reset sw", int'(sw), 'h049);
    report(strobe === 1'b0, "R2", "reset strobe", int'(strobe), 0);
    report(fault === 1'b0, "R2", "reset fault", int'(fault), 0);
  endtask

  task automatic test_basic();
    cfg_t c = '{100, 0, 0, 100, 80, 120, 90};
    run_period(c, "R4 R5 R6 R7 basic");
    c = '{100, 3, 4, 60, 150, 70, 170};
    run_period(c, "R4 R5 R6 R7 second pattern");
  endtask

  task automatic test_sector_sweep();
    for (int r = 0; r < 6; r++)
      for (int i = 0; i < 6; i++) begin
        cfg_t c = '{60, r, i, 90 + 10 * r, 60 + 12 * i, 110 - 5 * i, 70 + 9 * r};
        run_period(c, $sformatf("R5 R6 sweep rs=%0d is=%0d", r, i));
      end
  endtask

  task automatic test_empty_segments();
    cfg_t c = '{80, 2, 5, 0, 200, 150, 100};
    run_period(c, "R4 alpha segments empty");
    c = '{80, 4, 1, 180, 60, 0, 210};
    run_period(c, "R4 gamma segments empty");
    c = '{50, 1, 3, 10, 10, 10, 10};
    run_period(c, "R7 zero-only period");
  endtask

  task automatic test_overrun();
    cfg_t c = '{40, 5, 2, 255, 255, 255, 255};
    run_period(c, "R9 overrun truncation");
  endtask

  task automatic test_odd_period();
    cfg_t c = '{37, 1, 4, 130, 90, 100, 140};
    run_period(c, "R3 R4 odd period");
  endtask

  task automatic test_mid_change();
    cfg_t a = '{70, 0, 3, 120, 100, 90, 130};
    cfg_t b = '{54, 4, 0, 70, 160, 180, 40};
    drive(a);
    next_strobe();
    next_strobe();
    check_period(a, "R8 old config after mid change", a.p / 2, b);
    check_period(b, "R8 new config next period", -1, b);
  endtask

  task automatic test_fault();
    cfg_t good = '{50, 2, 1, 140, 90, 110, 120};
    cfg_t bad_c = '{50, 7, 1, 140, 90, 110, 120};
    logic [8:0] frozen;
    int bad_hold = 0;
    int bad_flag = 0;
    run_period(good, "R4 before fault");
    frozen = exp_sw(good, good.p - 1);
    drive(bad_c);
    next_strobe();
    next_strobe();
    for (int k = 0; k < bad_c.p; k++) begin
      if (k > 0) @(negedge clk);
      if (sw !== frozen) bad_hold++;
      if (fault !== 1'b1) bad_flag++;
    end
    report(bad_hold == 0, "R10", "held pattern mismatches", bad_hold, 0);
    report(bad_flag == 0, "R11", "fault low during illegal sector", bad_flag, 0);
    exp_fault = 1'b1;
    run_period(good, "R11 recovery with sticky fault");
  endtask

  initial begin
    cfg_t init_c = '{20, 0, 0, 0, 0, 0, 0};
    drive(init_c);
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_basic();
    test_sector_sweep();
    test_empty_segments();
    test_overrun();
    test_odd_period();
    test_mid_change();
    test_fault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule